// File: doc/BRIEF.md
# Standby Controller with Stabilization Timer

This block governs the low-power states of a processor core. When the core issues a sleep request, the block moves to one of two states, chosen by a control register bit. In light sleep the core clock keeps running. In deep standby the core clock is gated off. During deep standby the address bus and the bus strobes either hold their last values or are released to high impedance, again under register control.

A wake event ends light sleep on the next cycle. A wake event in deep standby starts a stabilization count, so that the oscillator can settle before the clock is released. The length of the count is a power of two picked from a 3-bit field. One code gives a short escape wait for an external clock, and one code is reserved and decodes as the longest wait. When the block returns to run it issues a one-cycle completion pulse. A plain 8-bit write/read port gives access to the control register.

Top module: `standby_ctrl`

## Requirements
- R1: After reset mode_o is 0, clk_en_o is 1, bus_float_o is 0, wake_done_o is 0 and reg_rdata_o reads 0x08. mode_o encodes run as 0, sleep as 1, standby as 2 and stabilizing as 3.
- R2: A write stores reg_wdata_i bits 7:3 in the control register, and they read back on the next cycle. Bits 2:0 always read 0 and writes to them are ignored. Bit 7 is the deep select, bits 6:4 are the wait code and bit 3 is the bus-hold bit.
- R3: A sleep request in run with bit 7 at 0 gives mode sleep on the next cycle, with clk_en_o held at 1. Any wake event in sleep gives run on the next cycle.
- R4: A sleep request in run with bit 7 at 1 gives mode standby on the next cycle. clk_en_o is 0 throughout standby and stabilizing.
- R5: In standby and stabilizing, bus_float_o equals the inverse of bit 3. In run and sleep it is 0.
- R6: A wake event in standby enters stabilizing. For wait codes 0 to 5, stabilizing lasts 2^(BASE_LOG2+code) cycles before run; the default is 8192 up to 262144.
- R7: Wait code 7 gives SHORT_WAIT cycles (default 16). The reserved code 6 gives the same wait as code 5.
- R8: A wake event during stabilizing is ignored. The wait code is sampled and the counter reloaded on every entry into standby, so later register writes do not change that wait.
- R9: wake_done_o is a one-cycle pulse in the first run cycle after each return from sleep or stabilizing.
- R10: A sleep request outside run has no effect, and a wake event in run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| sleep_req_i | input | 1 | Sleep request from the core |
| wake_i | input | 1 | Wake event strobe |
| clk_en_o | output | 1 | Core clock enable |
| bus_float_o | output | 1 | Float address bus and strobes when 1 |
| mode_o | output | 2 | Current power mode |
| wake_done_o | output | 1 | One-cycle pulse on return to run |

## Verification
Every wait code goes through a full standby cycle, so the doubling from code to code, the reserved code folding onto the longest wait, and the short escape code are each told apart by exact cycle counts. The bus-hold bit alternates across these runs, which separates floating from holding. Stray wake pulses are injected mid-count, and the wait code is rewritten during standby, which shows the count is neither restarted nor re-decoded. Light sleep is tried with repeated sleep requests and wakes in run, which shows those strobes have no effect outside their own mode.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_STBY  = 2'd2,
    MODE_STAB  = 2'd3
  } pd_mode_e;

  typedef struct packed {
    logic       deep;
    logic [2:0] wsel;
    logic       hold;
  } pd_ctrl_t;

  localparam int unsigned CtrlW = 8;
endpackage

// File: rtl/standby_regs.sv
module standby_regs
  import standby_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CtrlW-1:0] wdata_i,
  output pd_ctrl_t         ctrl_o,
  output logic [CtrlW-1:0] rdata_o
);
  pd_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{deep: 1'b0, wsel: 3'd0, hold: 1'b1};
    end else if (we_i) begin
      ctrl_q <= pd_ctrl_t'(wdata_i[CtrlW-1:3]);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = {ctrl_q, 3'b000};

  AST_REG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[CtrlW-1:3] == $past(wdata_i[CtrlW-1:3]))); // R2
endmodule

// File: rtl/standby_wait_dec.sv
module standby_wait_dec #(
  parameter int unsigned BASE_LOG2  = 13,
  parameter int unsigned SHORT_WAIT = 16,
  parameter int unsigned CNT_W      = BASE_LOG2 + 6
) (
  input  logic [2:0]       wsel_i,
  output logic [CNT_W-1:0] load_o
);
  localparam int unsigned MaxCode = 5;

  // load value is wait length minus one
  always_comb begin
    if (wsel_i == 3'd7) begin
      load_o = CNT_W'(SHORT_WAIT - 1);
    end else if (wsel_i > 3'(MaxCode)) begin
      load_o = (CNT_W'(1) << (BASE_LOG2 + MaxCode)) - CNT_W'(1);
    end else begin
      load_o = (CNT_W'(1) << (BASE_LOG2 + 32'(wsel_i))) - CNT_W'(1);
    end
  end
endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
#(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             wake_i,
  input  logic             deep_i,
  input  logic [CNT_W-1:0] load_i,
  output pd_mode_e         mode_o,
  output logic             done_o
);
  pd_mode_e         mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (mode_q)
        MODE_RUN: begin
          if (sleep_req_i) begin
            if (deep_i) begin
              mode_q <= MODE_STBY;
              cnt_q  <= load_i;
            end else begin
              mode_q <= MODE_SLEEP;
            end
          end
        end
        MODE_SLEEP: begin
          if (wake_i) begin
            mode_q <= MODE_RUN;
            done_q <= 1'b1;
          end
        end
        MODE_STBY: begin
          if (wake_i) mode_q <= MODE_STAB;
        end
        MODE_STAB: begin
          if (cnt_q == '0) begin
            mode_q <= MODE_RUN;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: mode_q <= MODE_RUN;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign done_o = done_q;

  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && sleep_req_i && !deep_i) |=> (mode_q == MODE_SLEEP)); // R3
  AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && wake_i) |=> (mode_q == MODE_RUN && done_q)); // R3
  AST_STBY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RUN && sleep_req_i && deep_i) |=> (mode_q == MODE_STBY)); // R4
  AST_STBY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STBY && !wake_i) |=> (mode_q == MODE_STBY && $stable(cnt_q))); // R6
  AST_STAB_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STAB && cnt_q != '0) |=> (mode_q == MODE_STAB && cnt_q == $past(cnt_q) - 1'b1)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R9
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int unsigned BASE_LOG2  = 13,
  parameter int unsigned SHORT_WAIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       sleep_req_i,
  input  logic       wake_i,
  output logic       clk_en_o,
  output logic       bus_float_o,
  output logic [1:0] mode_o,
  output logic       wake_done_o
);
  localparam int unsigned CntW = BASE_LOG2 + 6;

  pd_ctrl_t        ctrl;
  logic [CntW-1:0] load;
  pd_mode_e        mode;
  logic            gated;

  standby_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .ctrl_o  (ctrl),
    .rdata_o (reg_rdata_o)
  );

  standby_wait_dec #(
    .BASE_LOG2  (BASE_LOG2),
    .SHORT_WAIT (SHORT_WAIT),
    .CNT_W      (CntW)
  ) u_dec (
    .wsel_i (ctrl.wsel),
    .load_o (load)
  );

  standby_fsm #(
    .CNT_W (CntW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .wake_i      (wake_i),
    .deep_i      (ctrl.deep),
    .load_i      (load),
    .mode_o      (mode),
    .done_o      (wake_done_o)
  );

  assign gated       = (mode == MODE_STBY) || (mode == MODE_STAB);
  assign clk_en_o    = !gated;
  assign bus_float_o = gated && !ctrl.hold;
  assign mode_o      = mode;
endmodule

// File: tb/standby_ctrl_bench.sv
module standby_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int B = 5;
  localparam int SW = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sleep = 1'b0;
  logic       wake = 1'b0;
  logic       clk_en, bus_float, wake_done;
  logic [1:0] mode;

  int nchk = 0;
  int nerr = 0;

  int       m_mode;
  int       m_rem;
  bit [7:0] m_reg;
  bit       m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  standby_ctrl #(.BASE_LOG2(B), .SHORT_WAIT(SW)) u_standby_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .sleep_req_i (sleep),
    .wake_i      (wake),
    .clk_en_o    (clk_en),
    .bus_float_o (bus_float),
    .mode_o      (mode),
    .wake_done_o (wake_done)
  );

  function automatic int wait_of(int code);
    if (code == 7) return SW;
    if (code == 6) return 1 << (B + 5);
    return 1 << (B + code);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_reg = 8'h08; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      case (m_mode)
        0: if (sleep) begin
             if (m_reg[7]) begin m_mode = 2; m_rem = wait_of(int'(m_reg[6:4])); end
             else m_mode = 1;
           end
        1: if (wake) begin m_mode = 0; m_done = 1'b1; end
        2: if (wake) m_mode = 3;
        default: begin
          m_rem--;
          if (m_rem == 0) begin m_mode = 0; m_done = 1'b1; end
        end
      endcase
      if (we) m_reg = wdata & 8'hF8;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 mode", int'(mode), m_mode);
      chk("R4 clk_en", int'(clk_en), (m_mode < 2) ? 1 : 0);
      chk("R5 bus_float", int'(bus_float), (m_mode >= 2 && !m_reg[3]) ? 1 : 0);
      chk("R9 wake_done", int'(wake_done), int'(m_done));
      chk("R2 rdata", int'(rdata), int'(m_reg));
    end
  end

  task automatic write_reg(logic [7:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep = 1'b1;
    @(negedge clk); sleep = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic run_standby(int code, bit ope, bit disturb, bit rewrite);
    int n;
    write_reg({1'b1, 3'(code), ope, 3'b000});
    pulse_sleep();
    chk("R4 enter standby", int'(mode), 2);
    chk("R4 clock gated", int'(clk_en), 0);
    chk("R5 float", int'(bus_float), ope ? 0 : 1);
    if (rewrite) write_reg({1'b1, 3'd7, ope, 3'b000});
    repeat (2) @(negedge clk);
    pulse_wake();
    n = 0;
    while (mode == 2'd3) begin
      n++;
      wake = (disturb && n == 5);
      @(negedge clk);
    end
    wake = 1'b0;
    if (code <= 5) chk("R6 wait length", n, wait_of(code));
    else chk("R7 wait length", n, wait_of(code));
    if (disturb || rewrite) chk("R8 wait unchanged", n, wait_of(code));
    chk("R9 done pulse", int'(wake_done), 1);
    @(negedge clk);
    chk("R9 done clears", int'(wake_done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", int'(mode), 0);
    chk("R1 clk_en", int'(clk_en), 1);
    chk("R1 bus_float", int'(bus_float), 0);
    chk("R1 wake_done", int'(wake_done), 0);
    chk("R1 rdata", int'(rdata), 8'h08);

    write_reg(8'hFF);
    chk("R2 readback", int'(rdata), 8'hF8);
    write_reg(8'h07);
    chk("R2 low bits ignored", int'(rdata), 0);
    write_reg(8'h08);

    pulse_sleep();
    chk("R3 sleep mode", int'(mode), 1);
    chk("R3 clock runs", int'(clk_en), 1);
    pulse_sleep();
    chk("R10 sleep req in sleep", int'(mode), 1);
    repeat (3) @(negedge clk);
    pulse_wake();
    chk("R3 wake to run", int'(mode), 0);
    chk("R9 done pulse", int'(wake_done), 1);
    @(negedge clk);
    chk("R9 done clears", int'(wake_done), 0);
    pulse_wake();
    chk("R10 wake in run mode", int'(mode), 0);
    chk("R10 wake in run done", int'(wake_done), 0);

    for (int c = 0; c < 8; c++) begin
      run_standby(c, c[0], c == 2, c == 3);
    end
    run_standby(7, 1'b0, 1'b1, 1'b0);
    run_standby(7, 1'b1, 1'b0, 1'b0);

    write_reg(8'h08);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule